// File: doc/BRIEF.md
# VGA Raster Timing Generator with Pixel Queue

This block generates the horizontal and vertical timing of a VGA raster from one clock that runs at the pixel rate. A single parameterised sync counter is used twice. The horizontal instance advances on every clock. The vertical instance advances only when the horizontal instance emits its one-cycle gate pulse, so it steps once per line. Each instance drives an active-low sync output and a blanking term. The two blanking terms are ORed into one active-high blank flag.

A small first-in first-out queue accepts 16-bit words from an external pixel source. Each word carries one 9-bit colour. The queue is drained one pixel per clock, and only during active video. The three 3-bit colour buses feed an external resistor DAC, which gives 512 colours. The gate pulse of the vertical counter is exported as end-of-frame. The same pulse empties the queue, so every frame starts from a clean buffer. The pixel source uses end-of-frame to begin loading the next frame, and it holds off while the full flag is high.

All timing values are parameters. The defaults give 640x480 at 60 Hz with 800 clocks per line and 525 lines per frame.

Top module: `vga_raster_gen`

## Requirements
- R1: While rst_ni is low (asynchronous), hsync_n_o and vsync_n_o are 1, blank_o, eof_o and full_o are 0, the queue is empty and both counters sit at position 0.
- R2: The horizontal position counts 0 to H_TOTAL-1 once per clock and then wraps. hsync_n_o is low exactly when H_SYNC_START < position < H_SYNC_END.
- R3: The line counter advances once per line, on the clock edge at which the horizontal position leaves H_SYNC_START, and wraps after V_TOTAL-1. vsync_n_o is low exactly when V_SYNC_START < line < V_SYNC_END.
- R4: blank_o is high exactly when the horizontal position is at least H_ACTIVE or the line is at least V_ACTIVE.
- R5: eof_o is high for exactly one cycle per frame: the cycle with horizontal position H_SYNC_START and line V_SYNC_START. Both hsync_n_o and vsync_n_o fall on the following edge.
- R6: full_o is high once FIFO_DEPTH words are held. A write while full_o is high is dropped.
- R7: In a pixel word, bits [8:6] are red, [5:3] are green and [2:0] are blue, and bits [15:9] are ignored. Stored pixels appear in write order, one per active-video cycle. The oldest pixel is shown in the cycle it is at the head of the queue and is consumed at the end of that cycle.
- R8: While blank_o is high, the colour outputs are 0 and the queue is not read.
- R9: During active video with an empty queue, the colour outputs are 0.
- R10: The edge that ends an eof_o cycle empties the queue. A write presented in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_wr_i | input | 1 | Write strobe for pix_word_i |
| pix_word_i | input | 16 | Pixel word, colour in bits [8:0] |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| blank_o | output | 1 | High outside active video |
| red_o | output | 3 | Red DAC code |
| green_o | output | 3 | Green DAC code |
| blue_o | output | 3 | Blue DAC code |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| full_o | output | 1 | Queue cannot accept a word |

## Verification
The timing is checked with reduced parameters at hand-computed points in the frame. These points include each sync edge, the blanking boundaries of both axes, the mid-line step of the line counter and the wrap into the next frame. Together they separate an off-by-one in the strict sync comparisons from an error in where the line counter steps.

The queue is tried with four patterns. A burst loaded in blanking, with colour fields chosen so that swapped fields or unmasked upper bits show up, exposes reads during blanking and any reordering. An extra write into a full queue must not reappear after the queue drains. A short refill leaves an underrun tail. A full queue is then cleared by end-of-frame, with one more write in that same cycle, which tells a real flush apart from a retained head entry.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;
  localparam int COLOR_W = 3;
  localparam int PIX_W   = 3 * COLOR_W;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/vga_sync_axis.sv
module vga_sync_axis #(
  parameter int TOTAL      = 800,
  parameter int ACTIVE     = 640,
  parameter int SYNC_START = 655,
  parameter int SYNC_END   = 752
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  output logic sync_n_o,
  output logic blank_o,
  output logic gate_o
);
  localparam int CW = $clog2(TOTAL);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);
  localparam logic [CW-1:0] ACT  = CW'(ACTIVE);
  localparam logic [CW-1:0] S_LO = CW'(SYNC_START);
  localparam logic [CW-1:0] S_HI = CW'(SYNC_END);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (ce_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  // strict bounds on both sides of the pulse
  assign sync_n_o = !((cnt_q > S_LO) && (cnt_q < S_HI));
  assign blank_o  = (cnt_q >= ACT);
  // gate marks the edge on which the sync pulse begins
  assign gate_o   = ce_i && (cnt_q == S_LO);
endmodule

// File: rtl/vga_pix_fifo.sv
module vga_pix_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] din_i,
  input  logic          rd_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          push, pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign push    = wr_i && !full_o && !clr_i;
  assign pop     = rd_i && !empty_o && !clr_i;
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + AW'(1);
      if (pop)  rp_q <= rp_q + AW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
  import vga_raster_pkg::*;
#(
  parameter int H_ACTIVE     = 640,
  parameter int H_SYNC_START = 655,
  parameter int H_SYNC_END   = 752,
  parameter int H_TOTAL      = 800,
  parameter int V_ACTIVE     = 480,
  parameter int V_SYNC_START = 489,
  parameter int V_SYNC_END   = 492,
  parameter int V_TOTAL      = 525,
  parameter int FIFO_DEPTH   = 16,
  parameter int WORD_W       = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pix_wr_i,
  input  logic [WORD_W-1:0]  pix_word_i,
  output logic               hsync_n_o,
  output logic               vsync_n_o,
  output logic               blank_o,
  output logic [COLOR_W-1:0] red_o,
  output logic [COLOR_W-1:0] green_o,
  output logic [COLOR_W-1:0] blue_o,
  output logic               eof_o,
  output logic               full_o
);
  logic h_blank, v_blank, h_gate, v_gate;
  logic fifo_empty, show;
  rgb_t head, pix;
  logic unused_hi;

  assign unused_hi = ^pix_word_i[WORD_W-1:PIX_W];

  vga_sync_axis #(
    .TOTAL(H_TOTAL), .ACTIVE(H_ACTIVE),
    .SYNC_START(H_SYNC_START), .SYNC_END(H_SYNC_END)
  ) u_h (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(1'b1),
    .sync_n_o(hsync_n_o), .blank_o(h_blank), .gate_o(h_gate)
  );

  // line counter steps only on the horizontal gate
  vga_sync_axis #(
    .TOTAL(V_TOTAL), .ACTIVE(V_ACTIVE),
    .SYNC_START(V_SYNC_START), .SYNC_END(V_SYNC_END)
  ) u_v (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(h_gate),
    .sync_n_o(vsync_n_o), .blank_o(v_blank), .gate_o(v_gate)
  );

  assign blank_o = h_blank | v_blank;
  assign eof_o   = v_gate;
  assign show    = !blank_o && !fifo_empty;

  vga_pix_fifo #(.DW(PIX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(v_gate),
    .wr_i(pix_wr_i), .din_i(pix_word_i[PIX_W-1:0]),
    .rd_i(!blank_o), .dout_o(head),
    .empty_o(fifo_empty), .full_o(full_o)
  );

  assign pix     = show ? head : '0;
  assign red_o   = pix.r;
  assign green_o = pix.g;
  assign blue_o  = pix.b;
endmodule

// File: rtl/vga_raster_chk.sv
module vga_raster_chk #(
  parameter int H_SYNC_START = 655,
  parameter int H_SYNC_END   = 752
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hsync_n_o,
  input logic       vsync_n_o,
  input logic       blank_o,
  input logic [2:0] red_o,
  input logic [2:0] green_o,
  input logic [2:0] blue_o,
  input logic       eof_o,
  input logic       full_o
);
  localparam logic [15:0] H_LEN = 16'(H_SYNC_END - H_SYNC_START - 1);
  logic [15:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         low_run <= '0;
    else if (!hsync_n_o) low_run <= low_run + 16'd1;
    else                 low_run <= '0;
  end

  a_r2_hsync_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_n_o) |-> (low_run == H_LEN));
  a_r2_hsync_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_n_o |-> blank_o);
  a_r3_vsync_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_n_o |-> blank_o);
  a_r5_eof_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);
  a_r5_eof_vsync_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> ($fell(vsync_n_o) && $fell(hsync_n_o)));
  a_r6_full_held_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && blank_o && !eof_o) |=> full_o);
  a_r10_eof_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !full_o);
  a_r8_dark_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_o || !vsync_n_o) |-> ({red_o, green_o, blue_o} == 9'd0));
endmodule

bind vga_raster_gen vga_raster_chk #(
  .H_SYNC_START(H_SYNC_START), .H_SYNC_END(H_SYNC_END)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o),
  .blank_o(blank_o), .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
  .eof_o(eof_o), .full_o(full_o)
);

// File: tb/sim_vga_raster_gen.sv
module sim_vga_raster_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_wr_i = 1'b0;
  logic [15:0] pix_word_i = '0;
  logic        hsync_n_o, vsync_n_o, blank_o, eof_o, full_o;
  logic [2:0]  red_o, green_o, blue_o;

  int cyc;
  int n_chk = 0;
  int n_fail = 0;

  // line 16 clocks (active 8, sync at 10..12), frame 8 lines (active 4, sync lines 5..6), queue depth 4
  vga_raster_gen #(
    .H_ACTIVE(8), .H_SYNC_START(9), .H_SYNC_END(13), .H_TOTAL(16),
    .V_ACTIVE(4), .V_SYNC_START(4), .V_SYNC_END(7), .V_TOTAL(8),
    .FIFO_DEPTH(4), .WORD_W(16)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_wr_i(pix_wr_i), .pix_word_i(pix_word_i),
    .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o), .blank_o(blank_o),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .eof_o(eof_o), .full_o(full_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  // {cycle since reset, hsync_n, vsync_n, blank, eof}
  localparam logic [19:0] TV [12] = '{
    {16'd0,   4'b1100}, {16'd9,   4'b1110}, {16'd10,  4'b0110},
    {16'd13,  4'b1110}, {16'd16,  4'b1100}, {16'd57,  4'b1110},
    {16'd64,  4'b1110}, {16'd73,  4'b1111}, {16'd74,  4'b0010},
    {16'd105, 4'b1010}, {16'd106, 4'b0110}, {16'd128, 4'b1100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic goto(input int t);
    while (cyc < t) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [31:0] rgb();
    return {23'd0, red_o, green_o, blue_o};
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: state held while reset is low
    chk("R1 reset outputs", {hsync_n_o, vsync_n_o, blank_o, eof_o, full_o}, 5'b11000);
    rst_ni = 1'b1;

    // R2 R3 R4 R5: timing points over the first frame, queue left empty
    for (int i = 0; i < 12; i++) begin
      goto(int'(TV[i][19:4]));
      chk("R2/R3/R4/R5 timing vector",
          {hsync_n_o, vsync_n_o, blank_o, eof_o, red_o, green_o, blue_o},
          {TV[i][3:0], 9'd0});
    end

    // R6 R7: burst of five in blanking, the fifth while full
    goto(210);
    pix_wr_i = 1'b1; pix_word_i = 16'hA159; @(negedge clk_i);
    pix_word_i = 16'h0007; @(negedge clk_i);
    pix_word_i = 16'hFFC0; @(negedge clk_i);
    pix_word_i = 16'h0038; @(negedge clk_i);
    chk("R6 full after depth writes", full_o, 1);
    pix_word_i = 16'h01FF; @(negedge clk_i);
    pix_wr_i = 1'b0;

    goto(255);
    chk("R8 colour dark in blank with data queued", {blank_o, rgb()}, {1'b1, 32'd0});
    goto(256); chk("R7 pixel 0 fields, upper bits ignored", rgb(), 9'o531);
    goto(257); chk("R7 pixel 1 order", rgb(), 9'o007);
    goto(258); chk("R7 pixel 2 order", rgb(), 9'o700);
    goto(259); chk("R7 pixel 3 order", rgb(), 9'o070);
    goto(260); chk("R6 write while full dropped / R9 underrun", rgb(), 0);

    // R9: short refill leaves an underrun tail on the next line
    goto(264);
    pix_wr_i = 1'b1; pix_word_i = 16'h0092; @(negedge clk_i);
    pix_word_i = 16'h016D; @(negedge clk_i);
    pix_wr_i = 1'b0;
    goto(272); chk("R7 refill pixel 0", rgb(), 9'o222);
    goto(273); chk("R7 refill pixel 1", rgb(), 9'o555);
    goto(274); chk("R9 underrun dark", {blank_o, rgb()}, {1'b0, 32'd0});

    // R10: fill, then flush by end-of-frame with a write in that cycle
    goto(441);
    pix_wr_i = 1'b1; pix_word_i = 16'h01FF;
    repeat (4) @(negedge clk_i);
    pix_wr_i = 1'b0;
    chk("R6 full before flush", full_o, 1);
    goto(457);
    chk("R5 eof pulse", eof_o, 1);
    pix_wr_i = 1'b1; pix_word_i = 16'h01FF; @(negedge clk_i);
    pix_wr_i = 1'b0;
    chk("R10 flushed by eof", {full_o, eof_o}, 2'b00);
    goto(460);
    pix_wr_i = 1'b1; pix_word_i = 16'h00A5; @(negedge clk_i);
    pix_wr_i = 1'b0;
    goto(512); chk("R10 head is first post-flush write", rgb(), 9'o245);
    goto(513); chk("R10 nothing retained", rgb(), 0);

    // R1: asynchronous reset with hsync low and queue full
    goto(520);
    pix_wr_i = 1'b1; pix_word_i = 16'h0049;
    repeat (4) @(negedge clk_i);
    pix_wr_i = 1'b0;
    chk("R1 precondition hsync low, full", {hsync_n_o, full_o}, 2'b01);
    #2 rst_ni = 1'b0;
    #1 chk("R1 async reset", {hsync_n_o, vsync_n_o, blank_o, eof_o, full_o}, 5'b11000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 chk("R1 queue emptied by reset", {blank_o, rgb()}, {1'b0, 32'd0});

    summary();
    $finish;
  end
endmodule